// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Prioritizer

This block chooses one winner among up to 64 interrupt request lines, each already conditioned upstream. Every line has an individual enable bit and a 3-bit priority level taken from a flat level table. The winner is the line with the numerically smallest level. When several lines share that level, the lowest-numbered channel wins. The block reports the winner's channel and level on registered outputs. A level 0 winner drives the fast-interrupt line, and any other level drives the normal interrupt line.

Nesting is automatic. When the processor acknowledges the reported channel, the block pushes that channel's level onto an in-service stack. From then on, a request is forwarded only if its level value is strictly smaller than the level on top of the stack. An end-of-service strobe pops the stack and restores the previous masking. Because masking is strict, a level 0 request can always preempt a normal interrupt that is in service. Equal and lower priorities wait until servicing ends.

Top module: `nest_intc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fiq_o`, `irq_o` and `win_vld` are 0. The in-service stack is empty after reset.
- R2: A line takes part in arbitration only when both its `irq_req` bit and its `irq_en` bit are 1.
- R3: Among the qualifying lines, the smallest level value (0 is the most urgent, 7 the least) wins.
- R4: When qualifying lines share the winning level, the lowest channel index wins.
- R5: `fiq_o` is 1 exactly when the reported winner has level 0. `irq_o` is 1 exactly when the reported winner has a level from 1 to 7. The two are never both 1.
- R6: The winner outputs are registered and reflect the inputs seen at the previous clock edge. When no line qualifies, `win_vld` is 0 and `win_ch` and `win_lvl` read 0.
- R7: An `ack` pulse whose `ack_ch` equals `win_ch` while `win_vld` is 1 pushes `win_lvl` onto the stack. Afterwards only lines whose level value is strictly less than the stack top qualify.
- R8: A level 0 request is reported on `fiq_o` while an interrupt of level 1 to 7 is in service.
- R9: An `eos` pulse pops the top of the stack, and the masking of the level below it applies again.
- R10: An `eos` pulse while the stack is empty is ignored and does not wrap the depth.
- R11: An `ack` is ignored when `win_vld` is 0, when `ack_ch` differs from `win_ch`, or when the stack already holds 8 entries and no pop happens in the same cycle.
- R12: When `eos` and a valid `ack` arrive in the same cycle, the pop is applied first and then the push, so the top entry is replaced by `win_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Conditioned request per channel |
| irq_en | input | 64 | Enable per channel |
| irq_lvl | input | 192 | Level table, channel i at bits [3i+2:3i] |
| ack | input | 1 | Acknowledge strobe |
| ack_ch | input | 6 | Channel being acknowledged |
| eos | input | 1 | End-of-service strobe |
| fiq_o | output | 1 | Fast interrupt request (level 0 winner) |
| irq_o | output | 1 | Normal interrupt request (level 1 to 7 winner) |
| win_vld | output | 1 | A winner is reported |
| win_ch | output | 6 | Winning channel |
| win_lvl | output | 3 | Winning level |

## Verification
The hardest states to reach from the ports are a stack that holds all eight entries and an `eos` that arrives on an empty stack. The stimulus fills the stack by raising one request per level, from 7 down to 0, and acknowledging each reported winner in turn. Once full, every request is masked. The stack is then drained one pop at a time, with the next level revealed after each pop, and one extra `eos` is sent on the empty stack. That underflow case is exposed by a push that follows: it must mask a level 7 request, which a wrapped depth would fail to do. A reference model in the bench replays the stack and the arbitration every cycle and predicts the outputs.

// File: rtl/nest_intc.sv
module nest_intc #(
  parameter int N  = 64,
  parameter int LW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_req,
  input  logic [N-1:0]      irq_en,
  input  logic [N*LW-1:0]   irq_lvl,
  input  logic              ack,
  input  logic [$clog2(N)-1:0] ack_ch,
  input  logic              eos,
  output logic              fiq_o,
  output logic              irq_o,
  output logic              win_vld,
  output logic [$clog2(N)-1:0] win_ch,
  output logic [LW-1:0]     win_lvl
);
  localparam int CW    = $clog2(N);
  localparam int DEPTH = 1 << LW;
  localparam int PW    = $clog2(DEPTH);
  localparam int SPW   = $clog2(DEPTH + 1);

  logic [LW-1:0]  stk [DEPTH];
  logic [SPW-1:0] sp;
  logic [PW-1:0]  tidx, pidx;
  logic [LW:0]    lim;
  logic           nb_v;
  logic [CW-1:0]  nb_c;
  logic [LW-1:0]  nb_l, cur;
  logic           push, pop;

  assign tidx = PW'(sp - 1'b1);
  assign pidx = PW'(sp);
  assign lim  = (sp == '0) ? (LW+1)'(DEPTH) : {1'b0, stk[tidx]};

  always_comb begin
    nb_v = 1'b0;
    nb_c = '0;
    nb_l = '0;
    for (int i = 0; i < N; i++) begin
      cur = irq_lvl[i*LW +: LW];
      if (irq_req[i] && irq_en[i] && ({1'b0, cur} < lim) && (!nb_v || cur < nb_l)) begin
        nb_v = 1'b1;
        nb_c = CW'(i);
        nb_l = cur;
      end
    end
  end

  assign pop  = eos && (sp != '0);
  assign push = ack && win_vld && (ack_ch == win_ch) && ((sp != SPW'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_vld <= 1'b0;
      win_ch  <= '0;
      win_lvl <= '0;
      sp      <= '0;
    end else begin
      win_vld <= nb_v;
      win_ch  <= nb_c;
      win_lvl <= nb_l;
      sp      <= sp + SPW'(push) - SPW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && push) begin
      if (pop) stk[tidx] <= win_lvl;
      else     stk[pidx] <= win_lvl;
    end
  end

  assign fiq_o = win_vld && (win_lvl == '0);
  assign irq_o = win_vld && (win_lvl != '0);
endmodule

module nest_intc_chk #(
  parameter int N  = 64,
  parameter int LW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      irq_req,
  input logic [N-1:0]      irq_en,
  input logic              ack,
  input logic              eos,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              win_vld,
  input logic [$clog2(N)-1:0] win_ch,
  input logic [LW-1:0]     win_lvl,
  input logic [$clog2((1<<LW)+1)-1:0] sp
);
  localparam int DEPTH = 1 << LW;

  a_r5_fiq_irq_excl: assert property (@(posedge clk) disable iff (!rst_n) !(fiq_o && irq_o));
  a_r5_fiq_level0:   assert property (@(posedge clk) disable iff (!rst_n) fiq_o |-> (win_vld && win_lvl == '0));
  a_r6_vld_has_line: assert property (@(posedge clk) disable iff (!rst_n) win_vld == (fiq_o || irq_o));
  a_r6_idle_zero:    assert property (@(posedge clk) disable iff (!rst_n) !win_vld |-> (win_ch == '0 && win_lvl == '0));
  a_r2_qualified:    assert property (@(posedge clk) disable iff (!rst_n)
                       win_vld |-> ((($past(irq_req & irq_en)) >> win_ch) & N'(1)) != '0);
  a_r1_reset_clear:  assert property (@(posedge clk) $past(!rst_n) |-> (!win_vld && sp == '0));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) sp <= DEPTH);
  a_r10_empty_eos:   assert property (@(posedge clk) disable iff (!rst_n) (eos && !ack && sp == '0) |=> sp == '0);
  a_r11_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n) (!ack && !eos) |=> $stable(sp));
endmodule

bind nest_intc nest_intc_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
  .ack(ack), .eos(eos), .fiq_o(fiq_o), .irq_o(irq_o),
  .win_vld(win_vld), .win_ch(win_ch), .win_lvl(win_lvl), .sp(sp)
);

// File: tb/nest_intc_tb.sv
module nest_intc_tb;
  localparam int N = 64;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic [N*LW-1:0] irq_lvl = '0;
  logic ack = 1'b0, eos = 1'b0;
  logic [5:0] ack_ch = '0;
  logic fiq_o, irq_o, win_vld;
  logic [5:0] win_ch;
  logic [2:0] win_lvl;

  int checks = 0, errors = 0;
  logic [9:0] expq[$];
  string tagq[$];
  logic [2:0] m_stk[$];
  logic [9:0] m_win = '0;
  bit done = 0;

  always #10 clk = ~clk;

  nest_intc #(.N(N), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .irq_lvl(irq_lvl),
    .ack(ack), .ack_ch(ack_ch), .eos(eos), .fiq_o(fiq_o), .irq_o(irq_o),
    .win_vld(win_vld), .win_ch(win_ch), .win_lvl(win_lvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] model_arb();
    int lim = (m_stk.size() == 0) ? 8 : int'(m_stk[$]);
    for (int lv = 0; lv < lim; lv++)
      for (int c = 0; c < N; c++)
        if (irq_req[c] && irq_en[c] && int'(irq_lvl[c*LW +: LW]) == lv)
          return {1'b1, 6'(c), 3'(lv)};
    return '0;
  endfunction

  task automatic step(input logic a, input logic [5:0] ac, input logic e, input string tag);
    logic [9:0] nw;
    ack = a; ack_ch = ac; eos = e;
    nw = model_arb();
    if (e && m_stk.size() > 0) void'(m_stk.pop_back());
    if (a && m_win[9] && ac == m_win[8:3] && m_stk.size() < 8) m_stk.push_back(m_win[2:0]);
    m_win = nw;
    expq.push_back(nw);
    tagq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input string tag); step(1'b0, 6'd0, 1'b0, tag); endtask
  task automatic ack_win(input string tag); step(1'b1, m_win[8:3], 1'b0, tag); endtask

  task automatic set_line(input int c, input logic r, input logic e, input logic [2:0] l);
    irq_req[c] = r; irq_en[c] = e; irq_lvl[c*LW +: LW] = l;
  endtask

  always @(posedge clk) begin
    #5;
    if (expq.size() > 0) begin
      logic [9:0] ex;
      string t;
      ex = expq.pop_front();
      t = tagq.pop_front();
      check({t, " winner"}, {22'd0, win_vld, win_ch, win_lvl}, {22'd0, ex});
      check({t, " R5 fiq"}, {31'd0, fiq_o}, {31'd0, ex[9] && ex[2:0] == 0});
      check({t, " R5 irq"}, {31'd0, irq_o}, {31'd0, ex[9] && ex[2:0] != 0});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    set_line(3, 1, 1, 3'd0);
    repeat (3) @(negedge clk);
    check("R1 reset fiq", {31'd0, fiq_o}, 0);
    check("R1 reset irq", {31'd0, irq_o}, 0);
    check("R1 reset vld", {31'd0, win_vld}, 0);
    set_line(3, 0, 0, 3'd0);
    rst_n = 1'b1;
    idle("R1 after reset");

    set_line(5, 1, 0, 3'd3); idle("R2 disabled line");
    set_line(5, 1, 1, 3'd3); idle("R2 enabled line");
    set_line(5, 0, 1, 3'd3); idle("R6 idle zero");

    set_line(2, 1, 1, 3'd4); set_line(40, 1, 1, 3'd1); idle("R3 level wins");
    set_line(9, 1, 1, 3'd1); idle("R4 tie low channel");
    set_line(9, 0, 0, 3'd0); set_line(10, 1, 1, 3'd2); set_line(33, 1, 1, 3'd2);
    set_line(40, 0, 0, 3'd0); idle("R4 three way tie");
    set_line(63, 1, 1, 3'd0); idle("R5 level0 fiq");
    set_line(63, 0, 0, 3'd0); idle("R6 one cycle update");

    set_line(40, 1, 1, 3'd1); idle("R7 setup");
    step(1'b1, 6'd12, 1'b0, "R11 wrong channel");
    idle("R11 no push");
    ack_win("R7 ack");
    idle("R7 equal masked");
    set_line(12, 1, 1, 3'd1); idle("R7 same level masked");
    set_line(63, 1, 1, 3'd0); idle("R8 preempt");
    idle("R8 hold");
    set_line(63, 0, 0, 3'd0); idle("R8 release");
    step(1'b0, 6'd0, 1'b1, "R9 pop");
    idle("R9 unmasked");

    set_line(2, 0, 0, 0); set_line(10, 0, 0, 0); set_line(33, 0, 0, 0);
    set_line(12, 0, 0, 0); set_line(40, 0, 0, 0); idle("R6 all clear");
    step(1'b1, 6'd0, 1'b0, "R11 ack idle");
    step(1'b0, 6'd0, 1'b1, "R10 eos empty");
    set_line(20, 1, 1, 3'd3); idle("R10 setup");
    ack_win("R10 push");
    set_line(20, 0, 0, 0); set_line(21, 1, 1, 3'd7); idle("R10 masked by push");
    idle("R10 masked hold");
    step(1'b0, 6'd0, 1'b1, "R10 pop");
    idle("R10 visible");
    set_line(21, 0, 0, 0); idle("R10 clear");

    for (int l = 7; l >= 0; l--) begin
      set_line(50 - l, 1, 1, 3'(l));
      idle("R11 fill present");
      idle("R11 fill settle");
      ack_win("R11 fill ack");
      idle("R11 fill masked");
    end
    step(1'b1, 6'd50, 1'b0, "R11 ack full");
    idle("R11 full masked");
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 6'd0, 1'b1, "R9 drain pop");
      idle("R9 drain reveal");
    end
    step(1'b0, 6'd0, 1'b1, "R10 extra eos");
    idle("R10 after extra");

    for (int c = 43; c <= 50; c++) set_line(c, 0, 0, 0);
    set_line(30, 1, 1, 3'd5); idle("R12 setup");
    idle("R12 settle");
    ack_win("R12 push5");
    set_line(31, 1, 1, 3'd2); idle("R12 lvl2 shown");
    idle("R12 settle2");
    step(1'b1, m_win[8:3], 1'b1, "R12 pop and push");
    idle("R12 replaced");
    set_line(31, 0, 0, 0); idle("R12 lvl5 masked");
    step(1'b0, 6'd0, 1'b1, "R12 pop");
    idle("R12 empty");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule